// File: doc/BRIEF.md
# Tower-Field Byte Inverter

This block returns the multiplicative inverse of a byte in the binary field of 256 elements. It uses the polynomial basis reduced by x^8+x^4+x^3+x+1, the field of the AES byte substitution. The zero byte, which has no inverse, comes back as zero. The block is purely combinational: one byte in, one byte out, with no clock and no state. It is meant to sit in front of an affine stage inside a substitution unit, and that stage lies outside this block.

The block does not invert the byte directly. A linear change of basis carries the byte into a two-level field, in which each element is a1·β + a0 over a four-bit field reduced by y^4+y+1. In that field β^2 = β + 9. The inverse there needs only four-bit multiplications, one sixteen-entry four-bit inverse table and XORs. A second linear change of basis brings the result back.

The basis change is the field isomorphism that sends the power k of the byte FF to β^k. The block builds both matrices at elaboration from that rule.

Top module: `gf256_tower_inverter`

## Requirements
- R1: An input of 00 gives an output of 00.
- R2: For every nonzero input x, the output y satisfies x·y = 01. The product is taken in the polynomial field reduced by x^8+x^4+x^3+x+1 (0x11B), with bit 7 as the x^7 coefficient.
- R3: Inverting twice returns the original byte, for all 256 inputs.
- R4: The mapping is a bijection on all 256 byte values, and no nonzero input gives 00.
- R5: The output follows the input within the same clock period. No clock is needed and no state carries over from an earlier input.
- R6: Known pairs hold: 01→01, 02→8D, 53→CA and CA→53.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| din | input | 8 | Byte to invert, in polynomial basis |
| dout | output | 8 | Inverse of din, or 00 when din is 00 |

## Verification
The hardest case to reach from the ports is an error confined to a few bytes. A wrong entry in the four-bit table, or a wrong bit in one basis matrix, corrupts only the inputs whose tower image sends that value through the path. The bench therefore sweeps all 256 inputs exhaustively and compares each output with an inverse it computes as x^254. It then adds seeded random re-visits, with each new byte applied right after an unrelated one, to expose any dependence on an earlier input.

// File: rtl/gf256_tower_inverter.sv
module gf256_tower_inverter (
  input  logic [7:0] din,
  output logic [7:0] dout
);
  localparam logic [3:0] LAMBDA   = 4'b1001;
  localparam logic [7:0] GEN_BYTE = 8'hFF;
  localparam logic [7:0] BETA     = 8'h10;

  function automatic logic [3:0] gf4_mul(input logic [3:0] a, input logic [3:0] b);
    logic [3:0] acc, sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < 4; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = {sh[2:0], 1'b0} ^ (sh[3] ? 4'h3 : 4'h0);
    end
    return acc;
  endfunction

  function automatic logic [7:0] gf8_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc, sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = {sh[6:0], 1'b0} ^ (sh[7] ? 8'h1B : 8'h00);
    end
    return acc;
  endfunction

  function automatic logic [7:0] tower_mul(input logic [7:0] a, input logic [7:0] b);
    logic [3:0] hh;
    hh = gf4_mul(a[7:4], b[7:4]);
    return {hh ^ gf4_mul(a[7:4], b[3:0]) ^ gf4_mul(a[3:0], b[7:4]),
            gf4_mul(a[3:0], b[3:0]) ^ gf4_mul(LAMBDA, hh)};
  endfunction

  function automatic logic [3:0] gf4_inv(input logic [3:0] v);
    case (v)
      4'h1: return 4'h1;
      4'h2: return 4'h9;
      4'h3: return 4'hE;
      4'h4: return 4'hD;
      4'h5: return 4'hB;
      4'h6: return 4'h7;
      4'h7: return 4'h6;
      4'h8: return 4'hF;
      4'h9: return 4'h2;
      4'hA: return 4'hC;
      4'hB: return 4'h5;
      4'hC: return 4'hA;
      4'hD: return 4'h4;
      4'hE: return 4'h3;
      4'hF: return 4'h8;
      default: return 4'h0;
    endcase
  endfunction

  function automatic logic [63:0] build_cols(input logic to_tower);
    logic [7:0]  p, q;
    logic [63:0] cols;
    cols = '0;
    p = 8'h01;
    q = 8'h01;
    for (int k = 0; k < 255; k++) begin
      for (int j = 0; j < 8; j++) begin
        if (to_tower && p == (8'h01 << j)) cols[8*j +: 8] = q;
        if (!to_tower && q == (8'h01 << j)) cols[8*j +: 8] = p;
      end
      p = gf8_mul(p, GEN_BYTE);
      q = tower_mul(q, BETA);
    end
    return cols;
  endfunction

  function automatic logic [7:0] apply_cols(input logic [63:0] cols, input logic [7:0] v);
    logic [7:0] acc;
    acc = '0;
    for (int j = 0; j < 8; j++)
      if (v[j]) acc = acc ^ cols[8*j +: 8];
    return acc;
  endfunction

  localparam logic [63:0] FWD_COLS  = build_cols(1'b1);
  localparam logic [63:0] BACK_COLS = build_cols(1'b0);

  logic [7:0] t_in, t_out;
  logic [3:0] hi, lo, sum, delta, delta_inv;

  assign t_in      = apply_cols(FWD_COLS, din);
  assign hi        = t_in[7:4];
  assign lo        = t_in[3:0];
  assign sum       = hi ^ lo;
  assign delta     = gf4_mul(lo, sum) ^ gf4_mul(LAMBDA, gf4_mul(hi, hi));
  assign delta_inv = gf4_inv(delta);
  assign t_out     = {gf4_mul(hi, delta_inv), gf4_mul(sum, delta_inv)};
  assign dout      = apply_cols(BACK_COLS, t_out);

  always_comb begin
    // R1
    zero_map_chk: assert (din != 8'h00 || dout == 8'h00);
    // R2
    byte_product_chk: assert (din == 8'h00 || gf8_mul(din, dout) == 8'h01);
    // R2
    tower_product_chk: assert (din == 8'h00 || tower_mul(t_in, t_out) == 8'h01);
    // R2
    delta_nonzero_chk: assert (din == 8'h00 || delta != 4'h0);
    // R4
    nonzero_out_chk: assert (din == 8'h00 || dout != 8'h00);
  end
endmodule

// File: tb/tb_gf256_tower_inverter.sv
module tb_gf256_tower_inverter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] din = 8'h00;
  logic [7:0] dout;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [7:0] seen [256];

  always #4 clk = ~clk;

  gf256_tower_inverter dut (.din(din), .dout(dout));

  function automatic logic [7:0] ref_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc, sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = {sh[6:0], 1'b0} ^ (sh[7] ? 8'h1B : 8'h00);
    end
    return acc;
  endfunction

  function automatic logic [7:0] ref_inv(input logic [7:0] x);
    logic [7:0] r, b;
    r = 8'h01;
    b = x;
    for (int e = 254, i = 0; i < 8; i++) begin
      if (e[i]) r = ref_mul(r, b);
      b = ref_mul(b, b);
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [7:0] x, output logic [7:0] y);
    @(negedge clk);
    din = x;
    #1;
    y = dout;
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] y, y2;
    logic [255:0] hit;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 reset", dout, 8'h00);

    apply(8'h01, y); check("R6 01", y, 8'h01);
    apply(8'h02, y); check("R6 02", y, 8'h8D);
    apply(8'h53, y); check("R6 53", y, 8'hCA);
    apply(8'hCA, y); check("R6 CA", y, 8'h53);
    apply(8'h00, y); check("R1 zero", y, 8'h00);

    apply(8'hFF, y);
    din = 8'h53;
    #1;
    check("R5 same-period", dout, 8'hCA);

    for (int x = 0; x < 256; x++) begin
      apply(x[7:0], y);
      seen[x] = y;
      check("R2 value", y, ref_inv(x[7:0]));
      if (x != 0) check("R2 product", ref_mul(x[7:0], y), 8'h01);
      else check("R1 sweep", y, 8'h00);
    end

    hit = '0;
    for (int x = 0; x < 256; x++) hit[seen[x]] = 1'b1;
    checks++;
    if (hit != {256{1'b1}}) begin
      failures++;
      $display("FAIL R4 actual=%0d distinct expected=256", $countones(hit));
    end

    for (int x = 1; x < 256; x++)
      if (seen[x] == 8'h00) check("R4 nonzero", seen[x], ref_inv(x[7:0]));

    for (int x = 0; x < 256; x++) begin
      apply(seen[x], y);
      check("R3 involution", y, x[7:0]);
    end

    for (int n = 0; n < 2000; n++) begin
      logic [7:0] a, b;
      a = 8'($urandom);
      b = 8'($urandom);
      apply(a, y);
      apply(b, y2);
      check("R5 history", y2, ref_inv(b));
      check("R2 random", y, ref_inv(a));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule